// File: doc/BRIEF.md
# Host Command Packet Dispatcher

This block sits behind a host link and takes in command packets. Each packet is a pair of 32-bit words: a command word, then a data word. The block decodes the command word and carries out the packet in one of two ways. It either acts on the main controller itself, by loading control registers and issuing strobes, or it forwards both words over a shared SPI master to one of twelve transmitter boards. Locally it drives the following:

- the transmit pulse trigger
- the pulser enable
- an ADC delay value
- four receive-channel enable masks
- the ADC start line

It can also run a whole acquisition as one packet: pulse, start capture, wait for the capture memories to report full, stop capture, and then post a readout request to a downstream bulk-transfer engine. The request gives a start address and a byte length derived from a channel range.

The command word holds four byte fields: channel [7:0], opcode [15:8], board [23:16] and check [31:24]. The check byte chooses the decoding. 0xAA selects normal dispatch. 0x55 selects the receiver-test opcode set. Any other value selects legacy mode, which reads its opcode from bits [7:0]. Packets arrive on a valid/ready word stream with a last flag. The dispatcher accepts nothing while it is still working on a previous packet.

Top module: `cmd_dispatch`

## Requirements
- R1: A packet is accepted only if its second word carries `in_last` and its first does not. A packet of one word, or of three or more words, is drained and has no effect.
- R2: In normal mode (check 0xAA, board 0), opcode 1 loads `led` with data word bits [23:0].
- R3: Normal opcode 2 holds `pulse_trig` high for exactly PULSE_CYCLES consecutive clock cycles and then returns it low.
- R4: Normal opcode 3 clears `pulser_en` and opcode 4 sets it.
- R5: Normal opcode 5 loads `adc_delay` with the data word. Normal opcodes 6, 7, 8 and 9 load `rx_mask` group 0, 1, 2 and 3 (bits [24g+23:24g]) with data bits [23:0].
- R6: In normal mode a board value b from 1 to NUM_BOARDS sends the command word and then the data word as two SPI transfers on `spi_cs_n[b-1]`. The SPI link uses mode 0 and sends the most significant bit first. Chip select stays low for all 32 bits of each word. Between the two words chip select stays high for at least GAP_CYCLES cycles.
- R7: In normal mode, a board value above NUM_BOARDS is ignored, and so is an opcode with no defined meaning. No output changes and no SPI transfer takes place.
- R8: Normal opcode 10 waits for `adc_full`, clears `adc_start`, and then raises `rd_req_valid`. The request has `rd_req_addr` = data[31:24]·8192 and `rd_req_len` = data[23:16]·8192.
- R9: Normal opcodes 11 and 12 run a sequence: pulse as in R3, then set `adc_start`, wait for `adc_full`, clear `adc_start`, and request readout. Opcode 11 requests 8192 bytes starting at data[31:24]·8192. Opcode 12 requests the range as in R8. `adc_start` is never high while the pulse is high.
- R10: In receiver-test mode (check 0x55, board ignored), opcode 0 loads `adc_delay`, opcodes 1 to 4 load mask groups 0 to 3, opcode 5 sets `adc_start`, and opcode 6 performs the readout of R8.
- R11: In legacy mode (check neither 0xAA nor 0x55), a command word with bits [7:0] = 1 loads `led` from data[23:0]. Other values have no effect.
- R12: `in_ready` is low from the acceptance of a packet until that packet's work is finished. A readout request holds its address and length unchanged until `rd_req_ready`.
- R13: After reset, every output register is zero, `spi_cs_n` is all ones and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet word valid |
| in_data | input | 32 | Packet word |
| in_last | input | 1 | Marks the final word of a packet |
| in_ready | output | 1 | Word accepted on this cycle when valid |
| led | output | 24 | LED register |
| pulse_trig | output | 1 | Transmit pulse trigger |
| pulser_en | output | 1 | Pulser enable (low = shutdown) |
| adc_delay | output | 32 | ADC delay register |
| rx_mask | output | 96 | Four 24-bit receive-channel enable masks |
| adc_start | output | 1 | ADC capture start |
| adc_full | input | 1 | Capture memories full |
| rd_req_valid | output | 1 | Readout request valid |
| rd_req_ready | input | 1 | Readout request taken |
| rd_req_addr | output | 32 | Readout start byte address |
| rd_req_len | output | 32 | Readout byte length |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_cs_n | output | 12 | Per-board active-low chip selects |

## Verification
The bench sweeps every board address from 1 to 12. For each one it decodes the serial words and checks the select line, the bit order and the gap between the two words. A design that was off by one in the select index, sent the least significant bit first, or dropped the gap would show a wrong word or a wrong line. Packets that are too short or too long are sent to catch an assembler that executes whatever arrives ahead of the last flag. Board 13 and unused opcodes are sent to catch a decoder that falls through to a neighbouring action. The readout cases hold back `adc_full` and `rd_req_ready` and use first-channel and count values up to 255. These catch early requests, `adc_start` left set, a request that changes while it waits, a shift by the wrong amount, and single-channel shots that take the count field.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [7:0] check;
    logic [7:0] board;
    logic [7:0] opcode;
    logic [7:0] chan;
  } cmd_word_t;

  localparam logic [7:0] CHK_NORMAL = 8'hAA;
  localparam logic [7:0] CHK_RXTEST = 8'h55;

  localparam logic [7:0] OP_LED        = 8'd1;
  localparam logic [7:0] OP_PULSE      = 8'd2;
  localparam logic [7:0] OP_PULSER_OFF = 8'd3;
  localparam logic [7:0] OP_PULSER_ON  = 8'd4;
  localparam logic [7:0] OP_ADC_DELAY  = 8'd5;
  localparam int         OP_MASK_BASE  = 6;
  localparam logic [7:0] OP_READ       = 8'd10;
  localparam logic [7:0] OP_SHOT_ONE   = 8'd11;
  localparam logic [7:0] OP_SHOT_RANGE = 8'd12;

  localparam logic [7:0] RT_DELAY      = 8'd0;
  localparam int         RT_MASK_BASE  = 1;
  localparam logic [7:0] RT_START      = 8'd5;
  localparam logic [7:0] RT_READ       = 8'd6;

  localparam logic [7:0] LG_LED        = 8'd1;

  typedef enum logic [3:0] {
    S_IDLE, S_EXEC, S_PULSE, S_WAIT_FULL, S_REQ,
    S_SPI_CMD_W, S_GAP, S_SPI_DAT_W
  } seq_state_t;
endpackage

// File: rtl/cmd_rx.sv
module cmd_rx
  import cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_en,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              pkt_take,
  output logic              pkt_valid,
  output logic [WORD_W-1:0] pkt_cmd,
  output logic [WORD_W-1:0] pkt_dat
);
  typedef enum logic [1:0] {B_CMD, B_DAT, B_DRAIN} beat_t;
  beat_t beat;

  assign in_ready = accept_en && !pkt_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat      <= B_CMD;
      pkt_valid <= 1'b0;
      pkt_cmd   <= '0;
      pkt_dat   <= '0;
    end else begin
      if (pkt_take) pkt_valid <= 1'b0;
      if (in_valid && in_ready) begin
        case (beat)
          B_CMD: begin
            pkt_cmd <= in_data;
            beat    <= in_last ? B_CMD : B_DAT;
          end
          B_DAT: begin
            pkt_dat <= in_data;
            if (in_last) begin
              pkt_valid <= 1'b1;
              beat      <= B_CMD;
            end else begin
              beat <= B_DRAIN;
            end
          end
          default: if (in_last) beat <= B_CMD;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_spi_master.sv
module cmd_spi_master
  import cmd_pkg::*;
#(
  parameter int NSEL  = 12,
  parameter int HALF  = 2,
  localparam int SEL_W = (NSEL > 1) ? $clog2(NSEL) : 1,
  localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int ED_W  = $clog2(2 * WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic [NSEL-1:0]   cs_n
);
  localparam logic [ED_W-1:0] LAST_EDGE = ED_W'(2 * WORD_W - 1);
  localparam logic [HC_W-1:0] HC_END    = HC_W'(HALF - 1);

  logic              busy;
  logic [WORD_W-1:0] sh;
  logic [HC_W-1:0]   hcnt;
  logic [ED_W-1:0]   edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      sclk  <= 1'b0;
      mosi  <= 1'b0;
      cs_n  <= '1;
      sh    <= '0;
      hcnt  <= '0;
      edges <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cs_n  <= ~(NSEL'(1) << sel);
          mosi  <= word[WORD_W-1];
          sh    <= word << 1;
          hcnt  <= '0;
          edges <= '0;
        end
      end else if (hcnt == HC_END) begin
        hcnt  <= '0;
        sclk  <= ~sclk;
        edges <= edges + 1'b1;
        if (sclk) begin
          if (edges == LAST_EDGE) begin
            busy <= 1'b0;
            done <= 1'b1;
            cs_n <= '1;
            mosi <= 1'b0;
          end else begin
            mosi <= sh[WORD_W-1];
            sh   <= sh << 1;
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import cmd_pkg::*;
#(
  parameter int NUM_BOARDS   = 12,
  parameter int LED_W        = 24,
  parameter int MASK_W       = 24,
  parameter int NUM_GROUPS   = 4,
  parameter int CHAN_BYTES   = 8192,
  parameter int ADDR_W       = 32,
  parameter int PULSE_CYCLES = 3,
  parameter int GAP_CYCLES   = 50,
  localparam int SEL_W       = (NUM_BOARDS > 1) ? $clog2(NUM_BOARDS) : 1,
  localparam int CHAN_SHIFT  = $clog2(CHAN_BYTES),
  localparam int CNT_MAX     = (PULSE_CYCLES > GAP_CYCLES) ? PULSE_CYCLES : GAP_CYCLES,
  localparam int CNT_W       = $clog2(CNT_MAX + 1)
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                pkt_valid,
  input  logic [WORD_W-1:0]                   pkt_cmd,
  input  logic [WORD_W-1:0]                   pkt_dat,
  output logic                                pkt_take,
  output logic                                idle,
  output logic [LED_W-1:0]                    led,
  output logic                                pulse_trig,
  output logic                                pulser_en,
  output logic [WORD_W-1:0]                   adc_delay,
  output logic [NUM_GROUPS-1:0][MASK_W-1:0]   rx_mask,
  output logic                                adc_start,
  input  logic                                adc_full,
  output logic                                rd_req_valid,
  input  logic                                rd_req_ready,
  output logic [ADDR_W-1:0]                   rd_req_addr,
  output logic [ADDR_W-1:0]                   rd_req_len,
  output logic                                spi_start,
  output logic [WORD_W-1:0]                   spi_word,
  output logic [SEL_W-1:0]                    spi_sel,
  input  logic                                spi_done
);
  seq_state_t        st;
  cmd_word_t         cmd_q;
  logic [WORD_W-1:0] dat_q;
  logic [CNT_W-1:0]  cnt;
  logic              capture;
  logic              single;

  assign idle     = (st == S_IDLE);
  assign pkt_take = idle && pkt_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      cmd_q        <= '0;
      dat_q        <= '0;
      cnt          <= '0;
      capture      <= 1'b0;
      single       <= 1'b0;
      led          <= '0;
      pulse_trig   <= 1'b0;
      pulser_en    <= 1'b0;
      adc_delay    <= '0;
      rx_mask      <= '0;
      adc_start    <= 1'b0;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
      rd_req_len   <= '0;
      spi_start    <= 1'b0;
      spi_word     <= '0;
      spi_sel      <= '0;
    end else begin
      spi_start <= 1'b0;
      case (st)
        S_IDLE: if (pkt_valid) begin
          cmd_q <= pkt_cmd;
          dat_q <= pkt_dat;
          st    <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_IDLE;
          if (cmd_q.check == CHK_NORMAL) begin
            if (cmd_q.board == 8'd0) begin
              case (cmd_q.opcode)
                OP_LED:        led <= dat_q[LED_W-1:0];
                OP_PULSE: begin
                  pulse_trig <= 1'b1;
                  cnt        <= '0;
                  capture    <= 1'b0;
                  st         <= S_PULSE;
                end
                OP_PULSER_OFF: pulser_en <= 1'b0;
                OP_PULSER_ON:  pulser_en <= 1'b1;
                OP_ADC_DELAY:  adc_delay <= dat_q;
                OP_READ: begin
                  single <= 1'b0;
                  st     <= S_WAIT_FULL;
                end
                OP_SHOT_ONE, OP_SHOT_RANGE: begin
                  pulse_trig <= 1'b1;
                  cnt        <= '0;
                  capture    <= 1'b1;
                  single     <= (cmd_q.opcode == OP_SHOT_ONE);
                  st         <= S_PULSE;
                end
                default: ;
              endcase
              for (int g = 0; g < NUM_GROUPS; g++)
                if (cmd_q.opcode == 8'(OP_MASK_BASE + g))
                  rx_mask[g] <= dat_q[MASK_W-1:0];
            end else if (cmd_q.board <= 8'(NUM_BOARDS)) begin
              spi_word  <= cmd_q;
              spi_sel   <= SEL_W'(cmd_q.board - 8'd1);
              spi_start <= 1'b1;
              st        <= S_SPI_CMD_W;
            end
          end else if (cmd_q.check == CHK_RXTEST) begin
            case (cmd_q.opcode)
              RT_DELAY: adc_delay <= dat_q;
              RT_START: adc_start <= 1'b1;
              RT_READ: begin
                single <= 1'b0;
                st     <= S_WAIT_FULL;
              end
              default: ;
            endcase
            for (int g = 0; g < NUM_GROUPS; g++)
              if (cmd_q.opcode == 8'(RT_MASK_BASE + g))
                rx_mask[g] <= dat_q[MASK_W-1:0];
          end else if (cmd_q.chan == LG_LED) begin
            led <= dat_q[LED_W-1:0];
          end
        end
        S_PULSE: begin
          if (cnt == CNT_W'(PULSE_CYCLES - 1)) begin
            pulse_trig <= 1'b0;
            if (capture) begin
              adc_start <= 1'b1;
              st        <= S_WAIT_FULL;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT_FULL: if (adc_full) begin
          adc_start    <= 1'b0;
          rd_req_valid <= 1'b1;
          rd_req_addr  <= ADDR_W'(dat_q[31:24]) << CHAN_SHIFT;
          rd_req_len   <= ADDR_W'(single ? 8'd1 : dat_q[23:16]) << CHAN_SHIFT;
          st           <= S_REQ;
        end
        S_REQ: if (rd_req_ready) begin
          rd_req_valid <= 1'b0;
          st           <= S_IDLE;
        end
        S_SPI_CMD_W: if (spi_done) begin
          cnt <= '0;
          st  <= S_GAP;
        end
        S_GAP: begin
          if (cnt == CNT_W'(GAP_CYCLES - 1)) begin
            spi_word  <= dat_q;
            spi_start <= 1'b1;
            st        <= S_SPI_DAT_W;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SPI_DAT_W: if (spi_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
  import cmd_pkg::*;
#(
  parameter int NUM_BOARDS   = 12,
  parameter int LED_W        = 24,
  parameter int MASK_W       = 24,
  parameter int NUM_GROUPS   = 4,
  parameter int CHAN_BYTES   = 8192,
  parameter int ADDR_W       = 32,
  parameter int PULSE_CYCLES = 3,
  parameter int GAP_CYCLES   = 50,
  parameter int SCLK_HALF    = 2,
  localparam int SEL_W       = (NUM_BOARDS > 1) ? $clog2(NUM_BOARDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [31:0]                  in_data,
  input  logic                         in_last,
  output logic                         in_ready,
  output logic [LED_W-1:0]             led,
  output logic                         pulse_trig,
  output logic                         pulser_en,
  output logic [31:0]                  adc_delay,
  output logic [NUM_GROUPS*MASK_W-1:0] rx_mask,
  output logic                         adc_start,
  input  logic                         adc_full,
  output logic                         rd_req_valid,
  input  logic                         rd_req_ready,
  output logic [ADDR_W-1:0]            rd_req_addr,
  output logic [ADDR_W-1:0]            rd_req_len,
  output logic                         spi_sclk,
  output logic                         spi_mosi,
  output logic [NUM_BOARDS-1:0]        spi_cs_n
);
  logic              idle, pkt_valid, pkt_take;
  logic [WORD_W-1:0] pkt_cmd, pkt_dat;
  logic              spi_start, spi_done;
  logic [WORD_W-1:0] spi_word;
  logic [SEL_W-1:0]  spi_sel;
  logic [NUM_GROUPS-1:0][MASK_W-1:0] mask_q;

  assign rx_mask = mask_q;

  cmd_rx u_rx (
    .clk(clk), .rst(rst), .accept_en(idle),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .pkt_take(pkt_take), .pkt_valid(pkt_valid), .pkt_cmd(pkt_cmd), .pkt_dat(pkt_dat)
  );

  cmd_seq #(
    .NUM_BOARDS(NUM_BOARDS), .LED_W(LED_W), .MASK_W(MASK_W), .NUM_GROUPS(NUM_GROUPS),
    .CHAN_BYTES(CHAN_BYTES), .ADDR_W(ADDR_W), .PULSE_CYCLES(PULSE_CYCLES),
    .GAP_CYCLES(GAP_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst),
    .pkt_valid(pkt_valid), .pkt_cmd(pkt_cmd), .pkt_dat(pkt_dat), .pkt_take(pkt_take),
    .idle(idle), .led(led), .pulse_trig(pulse_trig), .pulser_en(pulser_en),
    .adc_delay(adc_delay), .rx_mask(mask_q), .adc_start(adc_start), .adc_full(adc_full),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
    .spi_start(spi_start), .spi_word(spi_word), .spi_sel(spi_sel), .spi_done(spi_done)
  );

  cmd_spi_master #(.NSEL(NUM_BOARDS), .HALF(SCLK_HALF)) u_spi (
    .clk(clk), .rst(rst), .start(spi_start), .word(spi_word), .sel(spi_sel),
    .done(spi_done), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk #(
  parameter int NUM_BOARDS   = 12,
  parameter int ADDR_W       = 32,
  parameter int CHAN_BYTES   = 8192,
  parameter int PULSE_CYCLES = 3,
  localparam int CHAN_SHIFT  = $clog2(CHAN_BYTES)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_ready,
  input logic                  pulse_trig,
  input logic                  adc_start,
  input logic                  rd_req_valid,
  input logic                  rd_req_ready,
  input logic [ADDR_W-1:0]     rd_req_addr,
  input logic [ADDR_W-1:0]     rd_req_len,
  input logic                  spi_sclk,
  input logic                  spi_mosi,
  input logic [NUM_BOARDS-1:0] spi_cs_n
);
  int unsigned hi_run;

  always_ff @(posedge clk) begin
    if (rst) hi_run <= 0;
    else     hi_run <= pulse_trig ? hi_run + 1 : 0;
  end

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    pulse_trig |-> hi_run < PULSE_CYCLES); // R3

  AST_PULSE_START_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(pulse_trig && adc_start)); // R9

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~spi_cs_n)); // R6

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (&spi_cs_n) |-> !spi_sclk); // R6

  AST_MOSI_HELD: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R6

  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_req_addr[CHAN_SHIFT-1:0] == '0 && rd_req_len[CHAN_SHIFT-1:0] == '0)); // R8

  AST_REQ_START_LOW: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> !adc_start); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=>
      (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len))); // R12

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (!pulse_trig && !rd_req_valid && (&spi_cs_n))); // R12
endmodule

bind cmd_dispatch cmd_dispatch_chk #(
  .NUM_BOARDS(NUM_BOARDS), .ADDR_W(ADDR_W), .CHAN_BYTES(CHAN_BYTES),
  .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .pulse_trig(pulse_trig),
  .adc_start(adc_start), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
  .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .spi_sclk(spi_sclk),
  .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
);

// File: tb/cmd_dispatch_tb.sv
module cmd_dispatch_tb;
  localparam int NB    = 12;
  localparam int PULSE = 3;
  localparam int GAP   = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready;
  logic [23:0] led;
  logic pulse_trig, pulser_en, adc_start;
  logic [31:0] adc_delay;
  logic [95:0] rx_mask;
  logic adc_full = 1'b0;
  logic rd_req_valid;
  logic rd_req_ready = 1'b1;
  logic [31:0] rd_req_addr, rd_req_len;
  logic spi_sclk, spi_mosi;
  logic [NB-1:0] spi_cs_n;

  always #10 clk = ~clk;

  cmd_dispatch #(.NUM_BOARDS(NB), .PULSE_CYCLES(PULSE), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .led(led), .pulse_trig(pulse_trig), .pulser_en(pulser_en),
    .adc_delay(adc_delay), .rx_mask(rx_mask), .adc_start(adc_start), .adc_full(adc_full),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_req_len(rd_req_len), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // observers, sampled on the falling edge
  int pulse_hi = 0, overlap = 0, rd_n = 0;
  logic [31:0] rd_addr_l, rd_len_l;
  int spi_n = 0, idle_run = 1000, cur_sel = -1, bits = 0;
  logic prev_act = 1'b0, prev_sclk = 1'b0;
  logic [31:0] shreg;
  logic [31:0] spi_w [0:63];
  int spi_s [0:63];
  int spi_b [0:63];
  int spi_g [0:63];

  always @(negedge clk) begin
    if (pulse_trig) pulse_hi++;
    if (pulse_trig && adc_start) overlap++;
    if (rd_req_valid && rd_req_ready) begin
      rd_n++; rd_addr_l = rd_req_addr; rd_len_l = rd_req_len;
    end
    if ((~spi_cs_n) != '0) begin
      if (!prev_act) begin
        bits = 0;
        for (int k = 0; k < NB; k++) if (!spi_cs_n[k]) cur_sel = k;
        if (spi_n < 64) spi_g[spi_n] = idle_run;
      end
      if (spi_sclk && !prev_sclk) begin shreg = {shreg[30:0], spi_mosi}; bits++; end
      idle_run = 0;
    end else begin
      if (prev_act && spi_n < 64) begin
        spi_w[spi_n] = shreg; spi_s[spi_n] = cur_sel; spi_b[spi_n] = bits; spi_n++;
      end
      idle_run++;
    end
    prev_act  = ((~spi_cs_n) != '0);
    prev_sclk = spi_sclk;
  end

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] d, input logic lst);
    in_valid = 1'b1; in_data = d; in_last = lst;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [31:0] c, input logic [31:0] d);
    send_word(c, 1'b0); send_word(d, 1'b1); wait_idle();
  endtask

  function automatic logic [31:0] cw(input logic [7:0] chk, input logic [7:0] brd,
                                     input logic [7:0] op, input logic [7:0] ch);
    return {chk, brd, op, ch};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R12 watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:0] led_ref;
    logic [95:0] mask_ref;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check("R13 led", led, 0);
    check("R13 pulse", pulse_trig, 0);
    check("R13 pulser_en", pulser_en, 0);
    check("R13 adc_start", adc_start, 0);
    check("R13 rd_valid", rd_req_valid, 0);
    check("R13 cs", spi_cs_n, {NB{1'b1}});
    check("R13 in_ready", in_ready, 1);

    // R2 LED sweep
    for (int i = 0; i < 6; i++) begin
      led_ref = 24'h13579B * (i + 1) ^ 24'hA5A5A5;
      send_pkt(cw(8'hAA, 0, 1, 8'(i)), {8'hEE, led_ref});
      check("R2 led", led, led_ref);
    end

    // R1 malformed lengths
    send_word(cw(8'hAA, 0, 1, 0), 1'b1); wait_idle();
    check("R1 short packet", led, led_ref);
    send_word(cw(8'hAA, 0, 1, 0), 1'b0);
    send_word(32'h0000_1234, 1'b0);
    send_word(32'h0000_5678, 1'b1); wait_idle();
    check("R1 long packet", led, led_ref);
    send_pkt(cw(8'hAA, 0, 1, 0), 32'h00C0FFEE);
    check("R1 recovers", led, 24'hC0FFEE);
    led_ref = 24'hC0FFEE;

    // R3 pulse width
    pulse_hi = 0;
    send_pkt(cw(8'hAA, 0, 2, 0), 0);
    check("R3 pulse width", pulse_hi, PULSE);
    check("R3 pulse low", pulse_trig, 0);

    // R4 pulser enable
    send_pkt(cw(8'hAA, 0, 4, 0), 0);
    check("R4 pulser on", pulser_en, 1);
    send_pkt(cw(8'hAA, 0, 3, 0), 0);
    check("R4 pulser off", pulser_en, 0);

    // R5 delay and masks
    send_pkt(cw(8'hAA, 0, 5, 0), 32'hDEAD_BEEF);
    check("R5 adc_delay", adc_delay, 32'hDEAD_BEEF);
    mask_ref = '0;
    for (int g = 0; g < 4; g++) begin
      send_pkt(cw(8'hAA, 0, 8'(6 + g), 0), {8'hFF, 24'h100001 * (g + 3)});
      mask_ref[g*24 +: 24] = 24'h100001 * (g + 3);
      check("R5 rx_mask", rx_mask, mask_ref);
    end

    // R7 ignored board and opcodes
    spi_n = 0;
    send_pkt(cw(8'hAA, 13, 1, 0), 32'h0012_3456);
    send_pkt(cw(8'hAA, 8'd200, 1, 0), 32'h0012_3456);
    check("R7 board above range led", led, led_ref);
    check("R7 board above range spi", spi_n, 0);
    send_pkt(cw(8'hAA, 0, 8'h30, 0), 32'h0012_3456);
    send_pkt(cw(8'hAA, 0, 0, 0), 32'h0012_3456);
    check("R7 undefined op led", led, led_ref);
    check("R7 undefined op mask", rx_mask, mask_ref);
    check("R7 undefined op delay", adc_delay, 32'hDEAD_BEEF);

    // R6 SPI forwarding to every board
    for (int b = 1; b <= NB; b++) begin
      spi_n = 0;
      send_pkt(cw(8'hAA, 8'(b), 8'(b + 40), 8'(b * 3)), 32'h8000_0001 ^ (32'h01010101 * b));
      check("R6 word count", spi_n, 2);
      check("R6 cmd word", spi_w[0], cw(8'hAA, 8'(b), 8'(b + 40), 8'(b * 3)));
      check("R6 data word", spi_w[1], 32'h8000_0001 ^ (32'h01010101 * b));
      check("R6 select cmd", spi_s[0], b - 1);
      check("R6 select dat", spi_s[1], b - 1);
      check("R6 bit count", spi_b[1], 32);
      check("R6 gap", (spi_g[1] >= GAP), 1);
    end
    check("R6 led untouched", led, led_ref);

    // R10 receiver-test start, then R8 read
    send_pkt(cw(8'h55, 8'h09, 5, 0), 0);
    check("R10 adc_start set", adc_start, 1);
    begin
      logic [7:0] fc [0:3];
      logic [7:0] nc [0:3];
      fc = '{8'd0, 8'd5, 8'd95, 8'd200};
      nc = '{8'd1, 8'd3, 8'd1, 8'd255};
      for (int i = 0; i < 4; i++) begin
        adc_full = 1'b0; rd_n = 0;
        send_word(cw(8'hAA, 0, 10, 0), 1'b0);
        send_word({fc[i], nc[i], 16'h1234}, 1'b1);
        repeat (20) @(negedge clk);
        check("R8 waits for full", rd_n, 0);
        check("R12 busy while waiting", in_ready, 0);
        adc_full = 1'b1;
        wait_idle();
        check("R8 one request", rd_n, 1);
        check("R8 addr", rd_addr_l, 32'(fc[i]) * 8192);
        check("R8 len", rd_len_l, 32'(nc[i]) * 8192);
        check("R8 adc_start cleared", adc_start, 0);
      end
    end

    // R12 request held while downstream stalls
    adc_full = 1'b1; rd_req_ready = 1'b0; rd_n = 0;
    send_word(cw(8'hAA, 0, 10, 0), 1'b0);
    send_word({8'd7, 8'd2, 16'h0}, 1'b1);
    repeat (15) @(negedge clk);
    check("R12 valid held", rd_req_valid, 1);
    check("R12 addr held", rd_req_addr, 7 * 8192);
    check("R12 in_ready low", in_ready, 0);
    rd_req_ready = 1'b1;
    wait_idle();
    check("R12 one transfer", rd_n, 1);

    // R9 combined shot, one channel then range
    for (int m = 0; m < 2; m++) begin
      adc_full = 1'b0; rd_n = 0; pulse_hi = 0; overlap = 0;
      send_word(cw(8'hAA, 0, 8'(11 + m), 0), 1'b0);
      send_word({8'd9, 8'd4, 16'h0}, 1'b1);
      repeat (20) @(negedge clk);
      check("R9 pulse width", pulse_hi, PULSE);
      check("R9 adc_start after pulse", adc_start, 1);
      check("R9 no early request", rd_n, 0);
      adc_full = 1'b1;
      wait_idle();
      check("R9 no overlap", overlap, 0);
      check("R9 addr", rd_addr_l, 9 * 8192);
      check("R9 len", rd_len_l, (m == 0) ? 8192 : 4 * 8192);
      check("R9 adc_start cleared", adc_start, 0);
    end

    // R10 receiver-test register writes and read
    send_pkt(cw(8'h55, 8'h33, 0, 0), 32'h0BAD_F00D);
    check("R10 adc_delay", adc_delay, 32'h0BAD_F00D);
    for (int g = 0; g < 4; g++) begin
      send_pkt(cw(8'h55, 0, 8'(1 + g), 0), 32'h00ABC000 + g);
      mask_ref[g*24 +: 24] = 24'hABC000 + 24'(g);
    end
    check("R10 rx_mask", rx_mask, mask_ref);
    adc_full = 1'b1; rd_n = 0;
    send_pkt(cw(8'h55, 0, 6, 0), {8'd3, 8'd6, 16'h0});
    check("R10 read addr", rd_addr_l, 3 * 8192);
    check("R10 read len", rd_len_l, 6 * 8192);
    check("R10 read count", rd_n, 1);

    // R11 legacy
    send_pkt(32'h1234_0001, 32'h0055_AA11);
    check("R11 legacy led", led, 24'h55AA11);
    send_pkt(32'h0000_0002, 32'h0011_1111);
    check("R11 legacy other op", led, 24'h55AA11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule